// File: doc/BRIEF.md
# Glitch-Free Card Clock Generator

This block derives the clock driven to a smart card from a fast input clock of up to 20 MHz. It divides that clock by 1, 2, 4 or 5, parks the output high or low on request, or lets the output follow a slow internal reference of about 1 MHz in a low-power mode. It also forces the output low whenever the activation sequencer has not enabled the card. Every change of ratio or mode is committed only at the end of a complete output period, so no shortened high or low phase reaches the card. With a 20 MHz input, system software selects a ratio of 2 or more to keep the card clock at or below 10 MHz.

Output timing is built from two registered levels per input cycle: one for the high half of the input clock and one for the low half. A rising-edge register and a falling-edge register are combined by XOR, so the output can change on either input edge. This gives divide-by-1 without gating logic and an exact 50 % duty cycle for divide-by-5. Controls sampled at rising edge k shape the output from rising edge k+1 on.

Top module: `cclk_gen`

## Requirements
- R1: Ratio select `div_sel_i` encodes 2'b00 = divide by 1, 2'b01 = by 2, 2'b10 = by 4, 2'b11 = by 5. In divide-by-N the output period is N input cycles, high for the first N input half-periods and low for the last N.
- R2: Divide-by-5 is high for exactly 5 input half-periods and low for exactly 5, starting on an input rising edge.
- R3: A new ratio or mode is applied only at the end of an output period. The current period always completes and ends with the output low, and the new setting starts on the next input rising edge.
- R4: With `stop_hi_i` set at a period boundary, the output rises at the next input rising edge and stays high for as long as the request stays asserted.
- R5: With `stop_lo_i` set at a period boundary, the output stays low for as long as the request stays asserted.
- R6: Priority at a boundary, highest first: stop-low, stop-high, low-power, divide.
- R7: In low-power mode the output follows `ref_i` through a two-stage synchronizer. Each level is held for whole input cycles, and the input level sampled at rising edge k appears from rising edge k+3.
- R8: With `en_i` low at a rising edge, the output is low for the whole of the next input cycle. When `en_i` returns, a new output period starts from a boundary.
- R9: While `rst_ni` is low, the output is low.
- R10: Controls sampled at rising edge k shape the output from rising edge k+1; the output never changes other than at an input clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock, up to 20 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Card clock enable from the activation sequencer |
| div_sel_i | input | 2 | Division ratio select |
| stop_hi_i | input | 1 | Request to park the card clock high |
| stop_lo_i | input | 1 | Request to park the card clock low |
| lowpwr_i | input | 1 | Request to run from the slow reference |
| ref_i | input | 1 | Slow internal reference, about 1 MHz, asynchronous |
| card_clk_o | output | 1 | Clock to the card |

## Verification
The assertions watch the sequencer on every cycle. They check that the mode register holds inside a period, that a divide period always ends on a low half, that the stop requests, their priority and the disable take effect in the cycle after they are sampled, and that the output at each rising edge equals the registered low-half level. Only the bench's scenarios can show the exact shape of each waveform: the half-period counts for every ratio, a ratio change made in the middle of a period, the three-cycle delay through the reference synchronizer, and the restart of the output after a disable or a reset. For these the bench compares both halves of every input cycle against a queue-based model.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  localparam int DIV_R0  = 1;
  localparam int DIV_R1  = 2;
  localparam int DIV_R2  = 4;
  localparam int DIV_R3  = 5;
  localparam int MAX_DIV = 5;
  localparam int PH_W    = $clog2(MAX_DIV);

  typedef logic [PH_W:0] len_t;

  typedef enum logic [2:0] {
    MD_DIV1, MD_DIV2, MD_DIV4, MD_DIV5, MD_STOP_HI, MD_STOP_LO, MD_LOWPWR
  } mode_e;

  function automatic mode_e sel_to_mode(input logic [1:0] sel);
    case (sel)
      2'b00:   return MD_DIV1;
      2'b01:   return MD_DIV2;
      2'b10:   return MD_DIV4;
      default: return MD_DIV5;
    endcase
  endfunction

  // Period length in input cycles; parked and low-power modes re-decide each cycle
  function automatic len_t mode_len(input mode_e m);
    case (m)
      MD_DIV1: return len_t'(DIV_R0);
      MD_DIV2: return len_t'(DIV_R1);
      MD_DIV4: return len_t'(DIV_R2);
      MD_DIV5: return len_t'(DIV_R3);
      default: return len_t'(1);
    endcase
  endfunction

  function automatic logic is_div(input mode_e m);
    return (m == MD_DIV1) || (m == MD_DIV2) || (m == MD_DIV4) || (m == MD_DIV5);
  endfunction
endpackage

// File: rtl/cclk_ref_sync.sv
module cclk_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sync_q[i] <= 1'b0;
      else if (i == 0) sync_q[i] <= d_i;
      else             sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/cclk_seq.sv
module cclk_seq
  import cclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] div_sel_i,
  input  logic       stop_hi_i,
  input  logic       stop_lo_i,
  input  logic       lowpwr_i,
  input  logic       ref_i,
  output logic       hi_o,
  output logic       lo_o
);
  mode_e           mode_q, mode_d, req_mode;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            hi_q, lo_q, hi_d, lo_d;
  logic            bound;
  len_t            len, nxt, dbl_hi, dbl_lo;

  assign bound = (ph_q == '0);

  always_comb begin
    if (stop_lo_i)      req_mode = MD_STOP_LO;
    else if (stop_hi_i) req_mode = MD_STOP_HI;
    else if (lowpwr_i)  req_mode = MD_LOWPWR;
    else                req_mode = sel_to_mode(div_sel_i);
  end

  assign mode_d = bound ? req_mode : mode_q;
  assign len    = mode_len(mode_d);
  assign dbl_hi = {ph_q, 1'b0};
  assign dbl_lo = {ph_q, 1'b1};
  assign nxt    = {1'b0, ph_q} + len_t'(1);
  assign ph_d   = (nxt >= len) ? '0 : nxt[PH_W-1:0];

  always_comb begin
    case (mode_d)
      MD_STOP_HI: begin hi_d = 1'b1;  lo_d = 1'b1;  end
      MD_STOP_LO: begin hi_d = 1'b0;  lo_d = 1'b0;  end
      MD_LOWPWR:  begin hi_d = ref_i; lo_d = ref_i; end
      default: begin
        // first N half-periods of a 2N half-period frame are high
        hi_d = dbl_hi < len;
        lo_d = dbl_lo < len;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_DIV1;
      ph_q   <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else if (!en_i) begin
      ph_q   <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ph_q   <= ph_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  a_r3_mode_held_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != '0) |=> $stable(mode_q));

  a_r3_period_ends_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bound && is_div(mode_q)) |-> !lo_q);

  a_r4_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bound && !stop_lo_i && stop_hi_i) |=> (hi_q && lo_q));

  a_r6_stop_low_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bound && stop_lo_i) |=> (!hi_q && !lo_q));

  a_r8_disable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!hi_q && !lo_q && ph_q == '0));
endmodule

// File: rtl/cclk_ddr_out.sv
module cclk_ddr_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  input  logic lo_i,
  output logic clk_o
);
  logic rise_q, fall_q, lo_q;

  // out = rise_q ^ fall_q: high half shows hi_i, low half shows lo_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      rise_q <= hi_i ^ fall_q;
      lo_q   <= lo_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= rise_q ^ lo_q;
  end

  assign clk_o = rise_q ^ fall_q;

  a_r10_low_half_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o == lo_q);
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
  import cclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] div_sel_i,
  input  logic       stop_hi_i,
  input  logic       stop_lo_i,
  input  logic       lowpwr_i,
  input  logic       ref_i,
  output logic       card_clk_o
);
  logic ref_s, hi_l, lo_l;

  cclk_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ref_i),
    .q_o   (ref_s)
  );

  cclk_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .div_sel_i(div_sel_i),
    .stop_hi_i(stop_hi_i),
    .stop_lo_i(stop_lo_i),
    .lowpwr_i (lowpwr_i),
    .ref_i    (ref_s),
    .hi_o     (hi_l),
    .lo_o     (lo_l)
  );

  cclk_ddr_out u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hi_i  (hi_l),
    .lo_i  (lo_l),
    .clk_o (card_clk_o)
  );
endmodule

// File: tb/cclk_gen_bench.sv
module cclk_gen_bench;
  localparam int T = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] div_sel_i = 2'b00;
  logic       stop_hi_i = 1'b0;
  logic       stop_lo_i = 1'b0;
  logic       lowpwr_i = 1'b0;
  logic       ref_i = 1'b0;
  logic       card_clk_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string req = "R9";
  int    ref_period = 0;
  int    ref_cnt = 0;

  // model state
  bit q[$];
  bit pend_h = 1'b0, pend_l = 1'b0;
  bit cur_h, cur_l;
  bit refh1 = 1'b0, refh2 = 1'b0;

  always #(T/2) clk_i = ~clk_i;

  cclk_gen u_cclk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .div_sel_i (div_sel_i),
    .stop_hi_i (stop_hi_i),
    .stop_lo_i (stop_lo_i),
    .lowpwr_i  (lowpwr_i),
    .ref_i     (ref_i),
    .card_clk_o(card_clk_o)
  );

  function automatic int ratio(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic model_edge();
    bit r;
    if (!rst_ni) begin
      q.delete();
      pend_h = 0; pend_l = 0; refh1 = 0; refh2 = 0;
      return;
    end
    r = refh2;
    refh2 = refh1;
    refh1 = ref_i;
    if (!en_i) begin
      q.delete();
      pend_h = 0; pend_l = 0;
      return;
    end
    if (q.size() == 0) begin
      if (stop_lo_i)      begin q.push_back(0); q.push_back(0); end
      else if (stop_hi_i) begin q.push_back(1); q.push_back(1); end
      else if (lowpwr_i)  begin q.push_back(r); q.push_back(r); end
      else begin
        int n = ratio(div_sel_i);
        for (int j = 0; j < 2*n; j++) q.push_back(j < n);
      end
    end
    pend_h = q.pop_front();
    pend_l = q.pop_front();
  endtask

  task automatic cmp(input bit act, input bit exp, input string half);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s half at %0t: actual %b expected %b", req, half, $time, act, exp);
    end
  endtask

  // one input cycle: edge, model, check high half, check low half
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      if (!rst_ni) begin cur_h = 0; cur_l = 0; end
      else begin cur_h = pend_h; cur_l = pend_l; end
      model_edge();
      #(T/4);
      cmp(card_clk_o, cur_h, "high");
      #(T/2);
      cmp(card_clk_o, cur_l, "low");
      if (ref_period > 0) begin
        ref_cnt++;
        if (ref_cnt >= ref_period) begin ref_cnt = 0; ref_i = ~ref_i; end
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(T*200000);
    n_bad++;
    $display("FAIL watchdog expired at %0t: actual hung expected done", $time);
    finish_run();
  end

  initial begin
    req = "R9";       run(4);           // reset holds output low
    rst_ni = 1'b1;
    req = "R8";       run(3);           // not enabled
    en_i = 1'b1;
    req = "R1";       div_sel_i = 2'b00; run(6);
    div_sel_i = 2'b01; run(8);
    div_sel_i = 2'b10; run(12);
    req = "R2";       div_sel_i = 2'b11; run(20);
    // R3: change ratio in the middle of a divide-by-5 period
    req = "R3";       run(2); div_sel_i = 2'b00; run(7);
    div_sel_i = 2'b10; run(1); div_sel_i = 2'b01; run(9);
    req = "R10";      div_sel_i = 2'b11; run(3); div_sel_i = 2'b01; run(8);
    // R4: park high, requested mid period
    req = "R4";       div_sel_i = 2'b11; run(1); stop_hi_i = 1'b1; run(10);
    stop_hi_i = 1'b0; run(10);
    req = "R5";       run(2); stop_lo_i = 1'b1; run(8); stop_lo_i = 1'b0; run(6);
    req = "R6";       stop_hi_i = 1'b1; stop_lo_i = 1'b1; lowpwr_i = 1'b1; run(6);
    stop_lo_i = 1'b0; run(6);
    stop_hi_i = 1'b0; lowpwr_i = 1'b0; run(10);
    // R7: follow slow reference
    req = "R7";       ref_period = 7; lowpwr_i = 1'b1; run(40);
    ref_period = 3; run(20);
    ref_period = 0; lowpwr_i = 1'b0; div_sel_i = 2'b10; run(12);
    // R8: disable mid period, then restart
    req = "R8";       div_sel_i = 2'b11; run(3); en_i = 1'b0; run(4);
    en_i = 1'b1; run(12);
    en_i = 1'b0; stop_hi_i = 1'b1; run(3); en_i = 1'b1; run(3); stop_hi_i = 1'b0; run(8);
    // R9: reset during operation
    req = "R9";       rst_ni = 1'b0; run(3); rst_ni = 1'b1;
    req = "R1";       div_sel_i = 2'b01; run(10);
    finish_run();
  end
endmodule